// File: doc/BRIEF.md
# Sample Window Monitor

This block sits beside a converter's result path. Every accepted sample carries a raw 12-bit value, a channel number and a group tag that marks it as regular or injected. The block checks the raw value against a programmable upper and lower bound. A sample that lies outside that range raises a sticky status flag. The flag can also drive an interrupt line.

Software programs the block through a small word-wide port. That port holds the two bounds, a group of control fields and the status flag. Two control fields work together. A single-channel bit restricts monitoring to one channel, given in a 5-bit field. Two group enables decide which kinds of sample are examined at all. The sample input is a valid/ready stream. The block never applies back-pressure, so `smp_ready` is always high once reset is released. A sample is taken on every clock edge where `smp_valid` is high.

Top module: `range_guard`

## Requirements
- R1: After reset the upper bound reads 0xFFF, the lower bound reads 0x000, the control word reads 0, the status flag reads 0 and `irq` is low.
- R2: Address 0 is the upper bound and address 1 is the lower bound. A write keeps only `cfg_wdata[11:0]`, and bits 15:12 of these addresses always read as zero.
- R3: A sample is out of range only when its raw value is strictly greater than the upper bound or strictly less than the lower bound. A value equal to either bound is in range.
- R4: An accepted out-of-range sample that passes R5 and R7 sets the flag at the clock edge that accepts it. The flag is visible in status bit 0 (address 3) from that edge on. `smp_ready` is 1 whenever reset is inactive.
- R5: The control word is at address 2. Bits [4:0] hold the channel, bit 5 selects single-channel mode, bit 6 enables regular samples, bit 7 enables injected samples, and bit 8 enables the interrupt. With bit 5 clear, every channel is monitored. With bit 5 set, only samples whose channel equals bits [4:0] are monitored, and this applies to both groups.
- R6: A control write whose channel value exceeds MAX_CH (default 17) stores channel 0. The other control fields still take the written value.
- R7: A sample with `smp_inj`=0 is regular and is examined only when bit 6 is set. A sample with `smp_inj`=1 is injected and is examined only when bit 7 is set. With both bits clear, no sample changes the flag.
- R8: The flag stays set until software writes address 3 with bit 0 high. A write with bit 0 low has no effect. If a new hit and a clear fall in the same cycle, the flag stays set.
- R9: `irq` is high exactly when the flag is set and control bit 8 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample stream valid |
| smp_ready | output | 1 | Sample stream ready, always high out of reset |
| smp_data | input | 12 | Raw converted value before alignment |
| smp_chan | input | 5 | Channel number of the sample |
| smp_inj | input | 1 | 1 = injected group, 0 = regular group |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for `cfg_addr` (combinational) |
| irq | output | 1 | Interrupt: flag gated by interrupt enable |

## Verification
The assertions assume `cfg_addr` and the sample fields are driven to known values in every cycle while reset is inactive. They also assume that a clear write arriving in the same cycle as a hit is meant to lose. The stimulus changes inputs only on falling edges and always drives every field. It mixes random samples and channels, including values outside the legal channel range, with random bound and control rewrites and random clears. Some of those clears deliberately land in the same cycle as a hit.

// File: rtl/range_guard_pkg.sv
package range_guard_pkg;
  localparam int unsigned REG_W = 16;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_UPPER  = 2'd0,
    A_LOWER  = 2'd1,
    A_CTRL   = 2'd2,
    A_STATUS = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic       irq_en;
    logic       inj_en;
    logic       reg_en;
    logic       single;
    logic [4:0] chan;
  } ctrl_t;
endpackage

// File: rtl/range_guard_regs.sv
module range_guard_regs
  import range_guard_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned CH_W   = 5,
  parameter int unsigned MAX_CH = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [DATA_W-1:0] upper,
  output logic [DATA_W-1:0] lower,
  output logic [CH_W-1:0]   chan,
  output logic              single,
  output logic              reg_en,
  output logic              inj_en,
  output logic              irq_en,
  output logic              clr
);
  localparam logic [DATA_W-1:0] UPPER_RST = {DATA_W{1'b1}};
  localparam int unsigned SINGLE_BIT = CH_W;

  logic [CH_W-1:0] chan_in;

  always_comb begin
    chan_in = wdata[CH_W-1:0];
    if (32'(chan_in) > MAX_CH) chan_in = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper  <= UPPER_RST;
      lower  <= '0;
      chan   <= '0;
      single <= 1'b0;
      reg_en <= 1'b0;
      inj_en <= 1'b0;
      irq_en <= 1'b0;
    end else if (we) begin
      case (reg_addr_e'(addr))
        A_UPPER: upper <= wdata[DATA_W-1:0];
        A_LOWER: lower <= wdata[DATA_W-1:0];
        A_CTRL: begin
          chan   <= chan_in;
          single <= wdata[SINGLE_BIT];
          reg_en <= wdata[SINGLE_BIT+1];
          inj_en <= wdata[SINGLE_BIT+2];
          irq_en <= wdata[SINGLE_BIT+3];
        end
        default: ;
      endcase
    end
  end

  assign clr = we && (reg_addr_e'(addr) == A_STATUS) && wdata[0];
endmodule

// File: rtl/range_guard_cmp.sv
module range_guard_cmp #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned CH_W   = 5
) (
  input  logic              valid,
  input  logic [DATA_W-1:0] data,
  input  logic [CH_W-1:0]   smp_chan,
  input  logic              inj,
  input  logic [DATA_W-1:0] upper,
  input  logic [DATA_W-1:0] lower,
  input  logic [CH_W-1:0]   sel_chan,
  input  logic              single,
  input  logic              reg_en,
  input  logic              inj_en,
  output logic              hit
);
  logic grp_ok, chan_ok, outside;

  always_comb begin
    grp_ok  = inj ? inj_en : reg_en;
    chan_ok = !single || (smp_chan == sel_chan);
    outside = (data > upper) || (data < lower);
    hit     = valid && grp_ok && chan_ok && outside;
  end
endmodule

// File: rtl/range_guard_flag.sv
module range_guard_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/range_guard.sv
module range_guard
  import range_guard_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned CH_W   = 5,
  parameter int unsigned MAX_CH = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [CH_W-1:0]   smp_chan,
  input  logic              smp_inj,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  output logic              irq
);
  logic [DATA_W-1:0] upper, lower;
  logic [CH_W-1:0]   chan;
  logic              single, reg_en, inj_en, irq_en, clr, hit, flag;
  ctrl_t             ctrl_view;

  range_guard_regs #(.DATA_W(DATA_W), .CH_W(CH_W), .MAX_CH(MAX_CH)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .upper(upper), .lower(lower), .chan(chan), .single(single),
    .reg_en(reg_en), .inj_en(inj_en), .irq_en(irq_en), .clr(clr)
  );

  range_guard_cmp #(.DATA_W(DATA_W), .CH_W(CH_W)) u_cmp (
    .valid(smp_valid), .data(smp_data), .smp_chan(smp_chan), .inj(smp_inj),
    .upper(upper), .lower(lower), .sel_chan(chan), .single(single),
    .reg_en(reg_en), .inj_en(inj_en), .hit(hit)
  );

  range_guard_flag u_flag (
    .clk(clk), .rst_n(rst_n), .hit(hit), .clr(clr), .flag(flag)
  );

  always_comb begin
    ctrl_view = '{irq_en: irq_en, inj_en: inj_en, reg_en: reg_en,
                  single: single, chan: 5'(chan)};
    cfg_rdata = '0;
    case (reg_addr_e'(cfg_addr))
      A_UPPER:  cfg_rdata[DATA_W-1:0] = upper;
      A_LOWER:  cfg_rdata[DATA_W-1:0] = lower;
      A_CTRL:   cfg_rdata[$bits(ctrl_t)-1:0] = ctrl_view;
      A_STATUS: cfg_rdata[0] = flag;
      default:  cfg_rdata = '0;
    endcase
  end

  assign smp_ready = rst_n;
  assign irq       = flag && irq_en;
endmodule

// File: rtl/range_guard_chk.sv
module range_guard_chk #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned CH_W   = 5,
  parameter int unsigned MAX_CH = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hit,
  input logic              clr,
  input logic              flag,
  input logic              irq,
  input logic              irq_en,
  input logic              reg_en,
  input logic              inj_en,
  input logic [CH_W-1:0]   chan,
  input logic [1:0]        cfg_addr,
  input logic [15:0]       cfg_rdata
);
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && flag)); // R9
  AST_HIT_NEEDS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (reg_en || inj_en)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R8
  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag); // R4
  AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(hit)); // R4
  AST_BOUND_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr[1] == 1'b0) |-> (cfg_rdata[15:DATA_W] == '0)); // R2
  AST_CHAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(chan) <= MAX_CH); // R6
endmodule

bind range_guard range_guard_chk #(.DATA_W(DATA_W), .CH_W(CH_W), .MAX_CH(MAX_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit(hit), .clr(clr), .flag(flag), .irq(irq),
  .irq_en(irq_en), .reg_en(reg_en), .inj_en(inj_en), .chan(chan),
  .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata)
);

// File: tb/test_range_guard.sv
module test_range_guard;
  localparam int MAX_CH = 17;
  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_valid = 0, smp_inj = 0, cfg_we = 0;
  logic smp_ready, irq;
  logic [11:0] smp_data = '0;
  logic [4:0]  smp_chan = '0;
  logic [1:0]  cfg_addr = 2'd3;
  logic [15:0] cfg_wdata = '0, cfg_rdata;

  int n_chk = 0, n_bad = 0;
  logic [11:0] m_hi = 12'hFFF, m_lo = 12'h000;
  logic [4:0]  m_ch = 0;
  logic m_single = 0, m_reg = 0, m_inj = 0, m_irq = 0, m_flag = 0;

  always #4 clk = ~clk;

  range_guard i_range_guard (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .smp_chan(smp_chan), .smp_inj(smp_inj),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq(irq)
  );

  function automatic logic exp_hit(logic v, logic [11:0] d, logic [4:0] c, logic inj);
    logic g = inj ? m_inj : m_reg;
    return v && g && (!m_single || c == m_ch) && (d > m_hi || d < m_lo);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, string req, logic [15:0] exp);
    cfg_addr = a; #1;
    check(req, cfg_rdata, exp);
  endtask

  // one clock: optional sample and optional write, then check flag and irq
  task automatic cycle(logic v, logic [11:0] d, logic [4:0] c, logic inj,
                       logic we, logic [1:0] a, logic [15:0] wd, string req);
    logic h, cl;
    smp_valid = v; smp_data = d; smp_chan = c; smp_inj = inj;
    cfg_we = we; cfg_addr = a; cfg_wdata = wd;
    h  = exp_hit(v, d, c, inj);
    cl = we && a == 2'd3 && wd[0];
    @(posedge clk);
    m_flag = h ? 1'b1 : (cl ? 1'b0 : m_flag);
    if (we) begin
      case (a)
        2'd0: m_hi = wd[11:0];
        2'd1: m_lo = wd[11:0];
        2'd2: begin
          m_ch = (int'(wd[4:0]) > MAX_CH) ? 5'd0 : wd[4:0];
          m_single = wd[5]; m_reg = wd[6]; m_inj = wd[7]; m_irq = wd[8];
        end
        default: ;
      endcase
    end
    @(negedge clk);
    smp_valid = 0; cfg_we = 0;
    rd(2'd3, {req, " flag"}, {15'd0, m_flag});
    check({req, " R9 irq"}, {15'd0, irq}, {15'd0, m_flag && m_irq});
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] wd, string req);
    cycle(0, 0, 0, 0, 1, a, wd, req);
  endtask

  task automatic smp(logic [11:0] d, logic [4:0] c, logic inj, string req);
    cycle(1, d, c, inj, 0, 3, 0, req);
  endtask

  initial begin
    #200000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(0, "R1 upper", 16'h0FFF); rd(1, "R1 lower", 16'h0000);
    rd(2, "R1 ctrl", 16'h0000);  rd(3, "R1 status", 16'h0000);
    check("R1 irq", {15'd0, irq}, 0);
    check("R4 ready", {15'd0, smp_ready}, 1);
    // R2 masking
    wr(0, 16'hF800, "R2"); rd(0, "R2 upper", 16'h0800);
    wr(1, 16'hA100, "R2"); rd(1, "R2 lower", 16'h0100);
    // R7 disabled: nothing flags
    smp(12'hFFF, 0, 0, "R7 off reg"); smp(12'h000, 3, 1, "R7 off inj");
    // R3 boundaries, all channels, regular only
    wr(2, 16'h0040, "R5");
    smp(12'h800, 2, 0, "R3 eq upper"); smp(12'h100, 2, 0, "R3 eq lower");
    smp(12'h800, 2, 1, "R7 inj gated");
    smp(12'h801, 2, 0, "R3 above");
    wr(3, 16'h0000, "R8 write0 no effect");
    wr(3, 16'h0001, "R8 clear");
    smp(12'h0FF, 9, 0, "R3 below");
    wr(3, 16'h0001, "R8 clear");
    // R5 single channel, both groups, irq on
    wr(2, 16'h01E5, "R5"); rd(2, "R5 ctrl", 16'h01E5);
    smp(12'hFFF, 4, 0, "R5 other chan");
    smp(12'hFFF, 5, 1, "R5 inj same chan");
    // R8 set wins over clear
    cycle(1, 12'h000, 5, 0, 1, 3, 16'h0001, "R8 set wins");
    // R6 out-of-range channel
    wr(2, 16'h01F4, "R6"); rd(2, "R6 ctrl", 16'h01E0);
    wr(2, 16'h0051, "R6"); rd(2, "R6 ctrl max", 16'h0051);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      logic [11:0] d = 12'($urandom);
      logic [4:0]  c = 5'($urandom_range(0, 20));
      logic        v = $urandom_range(0, 3) != 0;
      logic        j = 1'($urandom);
      if (i % 8 == 0) d = $urandom_range(0, 1) ? m_hi : m_lo;
      if (r < 2)      cycle(v, d, c, j, 1, 0, 16'($urandom), "R3 rnd upper");
      else if (r < 4) cycle(v, d, c, j, 1, 1, 16'($urandom_range(0, 1200)), "R3 rnd lower");
      else if (r < 7) cycle(v, d, c, j, 1, 2, 16'($urandom), "R5 rnd ctrl");
      else if (r < 15) cycle(v, d, c, j, 1, 3, 16'($urandom), "R8 rnd clear");
      else            cycle(v, d, c, j, 0, 3, 0, "R4 rnd sample");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule